// File: doc/BRIEF.md
# FIFO DMA Ready Signal Generator

This block drives the two active-low request lines a DMA controller watches when it moves characters into and out of one serial channel. It looks at the occupancy counts of the transmit and receive FIFOs, the programmed trigger-level selectors and a receive-timeout flag. From these it decides when the controller may write more transmit data and when it should collect received data.

Two signalling styles are supported. In single-character mode, the lines follow the presence of a character. This mode is also the only behaviour when the FIFOs are disabled and a lone holding register is used; that register shows as a count of 0 or 1. In block mode, the lines follow the trigger levels and the full and empty conditions, so one request can cover a burst of transfers. Both lines come from registers. The FIFOs themselves, the register file that holds the selectors and the interrupt logic sit outside this block.

Top module: `dmardy_gen`

## Requirements
- R1: While reset is high, at the next clock edge the transmit line goes low and the receive line goes high, whatever the other inputs are.
- R2: Block mode applies only when both `fifo_on` and `blk_sel` are 1. Any other combination gives single-character behaviour, and the block returns to single-character behaviour as soon as either input drops.
- R3: In single-character mode, the transmit line is low when the transmit count is 0 and high when the count is 1 or more.
- R4: In single-character mode, the receive line is low when the receive count is nonzero and high when it is 0.
- R5: In block mode, the transmit line goes high when the transmit count equals DEPTH (full).
- R6: In block mode, the transmit line goes low when the transmit count is at or below the transmit trigger level.
- R7: In block mode, when the transmit count is above the trigger level and below DEPTH, the transmit line keeps its previous value.
- R8: In block mode, the receive line goes low when the receive count is at or above the receive trigger level.
- R9: In block mode, a high `rx_tmo` with a nonzero receive count drives the receive line low, even when the count is below the trigger level.
- R10: In block mode, the receive line goes high only when the receive count is 0. An empty FIFO wins over a timeout. Otherwise the line holds its value until the trigger or timeout condition drives it low.
- R11: With DEPTH=64, the transmit selector values 0,1,2,3 give levels 8,16,32,56 (DEPTH/8, DEPTH/4, DEPTH/2, 7·DEPTH/8). The receive selector values 0,1,2,3 give levels 8,16,56,60 (DEPTH/8, DEPTH/4, 7·DEPTH/8, DEPTH-4).
- R12: Both lines are registered. A change on any input shows at the outputs at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_on | input | 1 | FIFOs enabled (0: single holding register) |
| blk_sel | input | 1 | DMA signalling select (0: single-character, 1: block) |
| tx_cnt | input | CNT_W (7) | Characters held in the transmit FIFO or holding register |
| rx_cnt | input | CNT_W (7) | Characters held in the receive FIFO or holding register |
| tx_lvl_sel | input | 2 | Transmit trigger-level selector |
| rx_lvl_sel | input | 2 | Receive trigger-level selector |
| rx_tmo | input | 1 | Receive timeout indication |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |
| rx_rdy_n | output | 1 | Receive DMA request, active low |

## Verification
In block mode, each line carries one bit of memory. A wrong held value therefore persists through a whole run of counts between the two thresholds and clears only at full, empty or a trigger crossing. The bench sequences are built so that such a stale bit is visible on the very next sampled edge. A wrong trigger decode shows one edge late or early, exactly at the count next to the chosen level. For that reason each selector value is driven one count above and at its level. A fault in the mode gating shows the first time a count arrives that the two styles treat differently.

// File: rtl/dmardy_pkg.sv
package dmardy_pkg;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BLOCK  = 1'b1
  } dma_style_e;

  // transmit threshold: the FIFO has drained to this many characters
  function automatic int unsigned tx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (depth * 7) / 8;
    endcase
  endfunction

  // receive threshold: the FIFO has filled to this many characters
  function automatic int unsigned rx_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return (depth * 7) / 8;
      default: return depth - 4;
    endcase
  endfunction

endpackage

// File: rtl/dmardy_lvl_decode.sv
module dmardy_lvl_decode #(
  parameter int unsigned DEPTH = 64,
  parameter bit          IS_RX = 1'b0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] level
);
  generate
    if (IS_RX) begin : g_rx
      always_comb level = CNT_W'(dmardy_pkg::rx_level(sel, DEPTH));
    end else begin : g_tx
      always_comb level = CNT_W'(dmardy_pkg::tx_level(sel, DEPTH));
    end
  endgenerate
endmodule

// File: rtl/dmardy_tx_gen.sv
module dmardy_tx_gen #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dmardy_pkg::dma_style_e style,
  input  logic [CNT_W-1:0]       count,
  input  logic [CNT_W-1:0]       level,
  output logic                   rdy_n
);
  import dmardy_pkg::*;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b0;
    end else if (style == DMA_SINGLE) begin
      rdy_n <= (count != '0);
    end else if (count >= FULL) begin
      rdy_n <= 1'b1;
    end else if (count <= level) begin
      rdy_n <= 1'b0;
    end
  end

  AST_TX_RESET: assert property (@(posedge clk) rst |=> !rdy_n); // R1
  AST_TX_SINGLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_SINGLE && count == '0) |=> !rdy_n); // R3
  AST_TX_SINGLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_SINGLE && count != '0) |=> rdy_n); // R3
  AST_TX_FULL: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && count == FULL) |=> rdy_n); // R5
  AST_TX_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && count <= level) |=> !rdy_n); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && count > level && count < FULL) |=> $stable(rdy_n)); // R7
endmodule

// File: rtl/dmardy_rx_gen.sv
module dmardy_rx_gen #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dmardy_pkg::dma_style_e style,
  input  logic [CNT_W-1:0]       count,
  input  logic [CNT_W-1:0]       level,
  input  logic                   timeout,
  output logic                   rdy_n
);
  import dmardy_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b1;
    end else if (style == DMA_SINGLE) begin
      rdy_n <= (count == '0);
    end else if (count == '0) begin
      rdy_n <= 1'b1;
    end else if (count >= level || timeout) begin
      rdy_n <= 1'b0;
    end
  end

  AST_RX_RESET: assert property (@(posedge clk) rst |=> rdy_n); // R1
  AST_RX_SINGLE_DATA: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_SINGLE && count != '0) |=> !rdy_n); // R4
  AST_RX_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> rdy_n); // R10
  AST_RX_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && count >= level && count != '0) |=> !rdy_n); // R8
  AST_RX_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && timeout && count != '0) |=> !rdy_n); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (style == DMA_BLOCK && !timeout && count != '0 && count < level) |=> $stable(rdy_n)); // R10
endmodule

// File: rtl/dmardy_gen.sv
module dmardy_gen #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_on,
  input  logic             blk_sel,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [1:0]       tx_lvl_sel,
  input  logic [1:0]       rx_lvl_sel,
  input  logic             rx_tmo,
  output logic             tx_rdy_n,
  output logic             rx_rdy_n
);
  import dmardy_pkg::*;

  dma_style_e       style;
  logic [CNT_W-1:0] tx_level;
  logic [CNT_W-1:0] rx_level;

  // block style needs the FIFOs; a lone holding register always signals per character
  always_comb style = (fifo_on && blk_sel) ? DMA_BLOCK : DMA_SINGLE;

  dmardy_lvl_decode #(.DEPTH(DEPTH), .IS_RX(1'b0)) i_tx_lvl (
    .sel(tx_lvl_sel), .level(tx_level));
  dmardy_lvl_decode #(.DEPTH(DEPTH), .IS_RX(1'b1)) i_rx_lvl (
    .sel(rx_lvl_sel), .level(rx_level));

  dmardy_tx_gen #(.DEPTH(DEPTH)) i_tx (
    .clk(clk), .rst(rst), .style(style), .count(tx_cnt),
    .level(tx_level), .rdy_n(tx_rdy_n));

  dmardy_rx_gen #(.DEPTH(DEPTH)) i_rx (
    .clk(clk), .rst(rst), .style(style), .count(rx_cnt),
    .level(rx_level), .timeout(rx_tmo), .rdy_n(rx_rdy_n));

  AST_NO_BLOCK_WITHOUT_FIFO: assert property (@(posedge clk) disable iff (rst)
    (!fifo_on && tx_cnt == '0) |=> !tx_rdy_n); // R2
endmodule

// File: tb/test_dmardy_gen.sv
module test_dmardy_gen;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int NV = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_on = 0, blk_sel = 0, rx_tmo = 0;
  logic [CNT_W-1:0] tx_cnt = '0, rx_cnt = '0;
  logic [1:0] tx_lvl_sel = '0, rx_lvl_sel = '0;
  logic tx_rdy_n, rx_rdy_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dmardy_gen #(.DEPTH(DEPTH)) i_dmardy_gen (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .blk_sel(blk_sel),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_lvl_sel(tx_lvl_sel),
    .rx_lvl_sel(rx_lvl_sel), .rx_tmo(rx_tmo),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n));

  // {req, fifo_on, blk_sel, tx_sel, rx_sel, tx_cnt, rx_cnt, tmo, exp_tx, exp_rx}
  localparam logic [26:0] VEC [NV] = '{
    {4'd3,  1'b0,1'b0,2'd0,2'd0,7'd0, 7'd0, 1'b0,1'b0,1'b1}, // R3 empty
    {4'd4,  1'b0,1'b0,2'd0,2'd0,7'd1, 7'd1, 1'b0,1'b1,1'b0}, // R4 one char each
    {4'd2,  1'b0,1'b1,2'd0,2'd0,7'd1, 7'd0, 1'b0,1'b1,1'b1}, // R2 select ignored without FIFOs
    {4'd3,  1'b1,1'b0,2'd0,2'd0,7'd0, 7'd5, 1'b0,1'b0,1'b0}, // R3 FIFO on, single style
    {4'd7,  1'b1,1'b1,2'd0,2'd0,7'd10,7'd3, 1'b0,1'b0,1'b0}, // R7 hold
    {4'd5,  1'b1,1'b1,2'd0,2'd0,7'd64,7'd0, 1'b0,1'b1,1'b1}, // R5 full
    {4'd7,  1'b1,1'b1,2'd0,2'd0,7'd40,7'd3, 1'b0,1'b1,1'b1}, // R7 hold high
    {4'd7,  1'b1,1'b1,2'd0,2'd0,7'd9, 7'd7, 1'b0,1'b1,1'b1}, // R7 one above level
    {4'd6,  1'b1,1'b1,2'd0,2'd0,7'd8, 7'd8, 1'b0,1'b0,1'b0}, // R6 R8 at level
    {4'd10, 1'b1,1'b1,2'd0,2'd0,7'd30,7'd2, 1'b0,1'b0,1'b0}, // R10 rx holds low
    {4'd5,  1'b1,1'b1,2'd0,2'd0,7'd64,7'd0, 1'b0,1'b1,1'b1}, // R5
    {4'd11, 1'b1,1'b1,2'd3,2'd0,7'd57,7'd0, 1'b0,1'b1,1'b1}, // R11 tx sel3 above
    {4'd11, 1'b1,1'b1,2'd3,2'd0,7'd56,7'd0, 1'b0,1'b0,1'b1}, // R11 tx sel3 at 56
    {4'd8,  1'b1,1'b1,2'd3,2'd2,7'd60,7'd55,1'b0,1'b0,1'b1}, // R8 below 56
    {4'd8,  1'b1,1'b1,2'd3,2'd2,7'd60,7'd56,1'b0,1'b0,1'b0}, // R8 at 56
    {4'd10, 1'b1,1'b1,2'd3,2'd2,7'd60,7'd1, 1'b0,1'b0,1'b0}, // R10 hold
    {4'd10, 1'b1,1'b1,2'd3,2'd2,7'd60,7'd0, 1'b0,1'b0,1'b1}, // R10 empty
    {4'd9,  1'b1,1'b1,2'd3,2'd2,7'd60,7'd3, 1'b1,1'b0,1'b0}, // R9 timeout
    {4'd10, 1'b1,1'b1,2'd3,2'd2,7'd60,7'd3, 1'b0,1'b0,1'b0}, // R10
    {4'd9,  1'b1,1'b1,2'd3,2'd2,7'd60,7'd0, 1'b1,1'b0,1'b1}, // R9 empty beats timeout
    {4'd11, 1'b1,1'b1,2'd3,2'd3,7'd64,7'd59,1'b0,1'b1,1'b1}, // R11 rx sel3 below 60
    {4'd11, 1'b1,1'b1,2'd3,2'd3,7'd64,7'd60,1'b0,1'b1,1'b0}, // R11 rx sel3 at 60
    {4'd11, 1'b1,1'b1,2'd1,2'd3,7'd17,7'd60,1'b0,1'b1,1'b0}, // R11 tx sel1 above
    {4'd11, 1'b1,1'b1,2'd1,2'd3,7'd16,7'd60,1'b0,1'b0,1'b0}, // R11 tx sel1 at 16
    {4'd5,  1'b1,1'b1,2'd2,2'd3,7'd64,7'd60,1'b0,1'b1,1'b0}, // R5
    {4'd11, 1'b1,1'b1,2'd2,2'd3,7'd33,7'd60,1'b0,1'b1,1'b0}, // R11 tx sel2 above
    {4'd11, 1'b1,1'b1,2'd2,2'd3,7'd32,7'd60,1'b0,1'b0,1'b0}, // R11 tx sel2 at 32
    {4'd11, 1'b1,1'b1,2'd2,2'd1,7'd32,7'd0, 1'b0,1'b0,1'b1}, // R11 rx sel1 empty
    {4'd11, 1'b1,1'b1,2'd2,2'd1,7'd32,7'd15,1'b0,1'b0,1'b1}, // R11 rx sel1 below
    {4'd11, 1'b1,1'b1,2'd2,2'd1,7'd32,7'd16,1'b0,1'b0,1'b0}, // R11 rx sel1 at 16
    {4'd2,  1'b1,1'b0,2'd2,2'd1,7'd5, 7'd0, 1'b0,1'b1,1'b1}  // R2 back to single
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "tx after reset", tx_rdy_n, 1'b0);
    check("R1", "rx after reset", rx_rdy_n, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {fifo_on, blk_sel, tx_lvl_sel, rx_lvl_sel, tx_cnt, rx_cnt, rx_tmo} = VEC[i][24:2];
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][26:23]), $sformatf("vec %0d tx", i), tx_rdy_n, VEC[i][1]);
      check($sformatf("R%0d", VEC[i][26:23]), $sformatf("vec %0d rx", i), rx_rdy_n, VEC[i][0]);
    end

    // R12: registered outputs, no change before the edge
    @(negedge clk);
    fifo_on = 1; blk_sel = 0; tx_cnt = 0; rx_cnt = 0; rx_tmo = 0;
    @(negedge clk);
    check("R12", "tx settled low", tx_rdy_n, 1'b0);
    tx_cnt = 7'd3; rx_cnt = 7'd2;
    #3;
    check("R12", "tx before edge", tx_rdy_n, 1'b0);
    check("R12", "rx before edge", rx_rdy_n, 1'b1);
    @(negedge clk);
    check("R12", "tx after edge", tx_rdy_n, 1'b1);
    check("R12", "rx after edge", rx_rdy_n, 1'b0);

    // R1: reset wins over inputs that would force the opposite levels
    blk_sel = 1; tx_cnt = 7'd64; rx_cnt = 7'd60; rst = 1'b1;
    @(negedge clk);
    check("R1", "tx in reset", tx_rdy_n, 1'b0);
    check("R1", "rx in reset", rx_rdy_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R5", "tx full after reset", tx_rdy_n, 1'b1);
    check("R8", "rx at level after reset", rx_rdy_n, 1'b0);

    finish_run();
  end
endmodule